// File: doc/BRIEF.md
# Split-Response Parity Error Reporter

This block is the error-reporting part of a bus initiator. It handles the case where a read request it issued is ended by the target with a split response, and a data parity error is found during that phase. An external detector pulses `par_err_i` for one clock per erroneous phase. The block then drives the parity-error and system-error pins, updates sticky status and interrupt-status bits, and raises one interrupt line.

Pin timing depends on the bus mode. The parity-error pin goes low two clocks after the erroneous phase in conventional mode and three clocks after it in PCI-X mode. Each pin and each interrupt-status bit has its own combination of enable and mask inputs. The request stays outstanding: the block tells the request queue to keep it pending, because the completer will still send completions for it. Status bits are cleared by writing ones through a small write port.

Top module: `bus_perr_report`

## Requirements
- R1: In conventional mode (`pcix_mode_i`=0), a parity error strobed in cycle c, with `per_en_i`=1, drives `perr_n_o` low for exactly one clock, in cycle c+2.
- R2: In PCI-X mode (`pcix_mode_i`=1), the same event drives `perr_n_o` low for exactly one clock, in cycle c+3.
- R3: When `per_en_i`=0, `perr_n_o` stays high. Each `perr_n_o` assertion sets status bit 0 (master parity) in the same cycle.
- R4: `serr_n_o` pulses low together with `perr_n_o`, but only when `serr_en_i`=1 and `udr_en_i`=0.
- R5: Each `serr_n_o` assertion sets status bit 1. It also sets interrupt-status bit 1 when mask bit `imask_i[1]`=0.
- R6: Each `serr_n_o` assertion sets interrupt-status bit 2 when `serr_det_ie_i`=1.
- R7: Every strobed parity error sets status bit 2 (detected parity) in the next cycle, whatever `per_en_i` is. It sets interrupt-status bit 3 only when `imask_i[2]`=0.
- R8: Each `perr_n_o` assertion sets interrupt-status bit 0 only when `imask_i[0]`=0.
- R9: `keep_pend_o` is high in every cycle in which `par_err_i` is high, and low otherwise.
- R10: All status bits are sticky. A write with `wr_en_i`=1 clears the bits where `wr_data_i` has a one: status when `wr_sel_i`=0, interrupt status when `wr_sel_i`=1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: `irq_o` is high exactly when any interrupt-status bit is set.
- R12: Parity errors on consecutive cycles each produce their own `perr_n_o` pulse, so no event is lost.
- R13: After reset, `perr_n_o` and `serr_n_o` are high, and all status bits, all interrupt-status bits and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_err_i | input | 1 | Parity error found in a split-response phase |
| pcix_mode_i | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| per_en_i | input | 1 | Enable for parity error response |
| serr_en_i | input | 1 | Enable for the system-error pin |
| udr_en_i | input | 1 | Enable for uncorrectable-data recovery; blocks system error |
| serr_det_ie_i | input | 1 | Enable for the system-error-detected interrupt |
| imask_i | input | 3 | Interrupt masks: [0] master parity, [1] system error, [2] detected parity |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_sel_i | input | 1 | 0 = status, 1 = interrupt status |
| wr_data_i | input | 4 | Bits to clear |
| perr_n_o | output | 1 | Parity-error pin, active low |
| serr_n_o | output | 1 | System-error pin, active low |
| status_o | output | 3 | [0] master parity, [1] system error asserted, [2] detected parity |
| istat_o | output | 4 | [0] master parity, [1] system error asserted, [2] system error detected, [3] detected parity |
| irq_o | output | 1 | Interrupt request |
| keep_pend_o | output | 1 | Tells the queue to keep the request outstanding |

## Verification
The bench uses the default delays, two clocks for conventional mode and three for PCI-X mode. With these values both taps of the delay line are used, and back-to-back errors put two events in flight at once, which tests that none is lost. A vector table covers the enable and mask combinations in both modes. Directed tests follow for the reset state, for a set and a clear in the same cycle, and for the stalled request.

// File: rtl/bus_perr_report.sv
module bus_perr_report #(
  parameter int CONV_DLY = 2,
  parameter int PCIX_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_err_i,
  input  logic       pcix_mode_i,
  input  logic       per_en_i,
  input  logic       serr_en_i,
  input  logic       udr_en_i,
  input  logic       serr_det_ie_i,
  input  logic [2:0] imask_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic       perr_n_o,
  output logic       serr_n_o,
  output logic [2:0] status_o,
  output logic [3:0] istat_o,
  output logic       irq_o,
  output logic       keep_pend_o
);
  localparam int STG = PCIX_DLY - 1;

  logic [STG-1:0] pp_q, ps_q;
  logic perr_q, serr_q;
  logic fire_p, fire_s;
  logic [2:0] sts_set, sts_clr;
  logic [3:0] ist_set, ist_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_q <= '0;
      ps_q <= '0;
    end else begin
      pp_q[0] <= par_err_i & per_en_i;
      ps_q[0] <= par_err_i & per_en_i & serr_en_i & ~udr_en_i;
      for (int i = 1; i < STG; i++) begin
        pp_q[i] <= pp_q[i-1];
        ps_q[i] <= ps_q[i-1];
      end
    end
  end

  assign fire_p = pcix_mode_i ? pp_q[PCIX_DLY-2] : pp_q[CONV_DLY-2];
  assign fire_s = pcix_mode_i ? ps_q[PCIX_DLY-2] : ps_q[CONV_DLY-2];

  assign sts_set = {par_err_i, fire_s, fire_p};
  assign ist_set = {par_err_i & ~imask_i[2], fire_s & serr_det_ie_i,
                    fire_s & ~imask_i[1], fire_p & ~imask_i[0]};
  assign sts_clr = (wr_en_i && !wr_sel_i) ? wr_data_i[2:0] : 3'b000;
  assign ist_clr = (wr_en_i && wr_sel_i) ? wr_data_i : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q   <= 1'b0;
      serr_q   <= 1'b0;
      status_o <= '0;
      istat_o  <= '0;
    end else begin
      perr_q   <= fire_p;
      serr_q   <= fire_s;
      status_o <= (status_o & ~sts_clr) | sts_set;
      istat_o  <= (istat_o & ~ist_clr) | ist_set;
    end
  end

  assign perr_n_o    = ~perr_q;
  assign serr_n_o    = ~serr_q;
  assign irq_o       = |istat_o;
  assign keep_pend_o = par_err_i;
endmodule

module bus_perr_report_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       par_err_i,
  input logic       pcix_mode_i,
  input logic       per_en_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [3:0] wr_data_i,
  input logic       perr_n_o,
  input logic       serr_n_o,
  input logic [2:0] status_o
);
  assert_perr_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i && per_en_i && !pcix_mode_i) |-> ##2 !perr_n_o);
  assert_perr_pcix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i && per_en_i && pcix_mode_i) |-> ##3 !perr_n_o);
  assert_mpe_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> status_o[0]);
  assert_serr_with_perr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> !perr_n_o);
  assert_serr_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> status_o[1]);
  assert_dpe_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_i |=> status_o[2]);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && !(wr_en_i && !wr_sel_i && wr_data_i[2])) |=> status_o[2]);
endmodule

bind bus_perr_report bus_perr_report_chk u_chk (
  .clk(clk), .rst_n(rst_n), .par_err_i(par_err_i), .pcix_mode_i(pcix_mode_i),
  .per_en_i(per_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
  .status_o(status_o)
);

// File: tb/test_bus_perr_report.sv
`timescale 1ns/1ps
module test_bus_perr_report;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_err = 1'b0, pcix = 1'b0, per_en = 1'b0, serr_en = 1'b0, udr_en = 1'b0, sdie = 1'b0;
  logic [2:0] imask = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic perr_n, serr_n, irq, keep;
  logic [2:0] sts;
  logic [3:0] ist;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bus_perr_report i_bus_perr_report (
    .clk(clk), .rst_n(rst_n), .par_err_i(par_err), .pcix_mode_i(pcix),
    .per_en_i(per_en), .serr_en_i(serr_en), .udr_en_i(udr_en),
    .serr_det_ie_i(sdie), .imask_i(imask), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .perr_n_o(perr_n), .serr_n_o(serr_n),
    .status_o(sts), .istat_o(ist), .irq_o(irq), .keep_pend_o(keep)
  );

  typedef struct packed {
    logic pcix, per, sen, udr, sdie;
    logic [2:0] msk;
    logic [1:0] pd;
    logic xs;
    logic [2:0] sts;
    logic [3:0] ist;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b1,3'b000,2'd2,1'b1,3'b111,4'b1111},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,3'b000,2'd3,1'b1,3'b111,4'b1111},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,3'b000,2'd0,1'b0,3'b100,4'b1000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,3'b000,2'd3,1'b0,3'b101,4'b1001},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,3'b000,2'd2,1'b0,3'b101,4'b1001},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,3'b111,2'd2,1'b1,3'b111,4'b0000},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,3'b011,2'd3,1'b1,3'b111,4'b1100},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,3'b100,2'd2,1'b1,3'b111,4'b0011}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'hF;
    @(negedge clk); wr_sel = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  int pfirst, pcnt, sfirst;
  task automatic watch(input int n);
    pfirst = 0; pcnt = 0; sfirst = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      par_err = 1'b0;
      if (!perr_n) begin if (pfirst == 0) pfirst = k; pcnt++; end
      if (!serr_n && sfirst == 0) sfirst = k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 perr_n", int'(perr_n), 1);
    chk("R13 serr_n", int'(serr_n), 1);
    chk("R13 status", int'(sts), 0);
    chk("R13 istat", int'(ist), 0);
    chk("R13 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      pcix = TBL[v].pcix; per_en = TBL[v].per; serr_en = TBL[v].sen;
      udr_en = TBL[v].udr; sdie = TBL[v].sdie; imask = TBL[v].msk;
      clear_all();
      @(negedge clk); par_err = 1'b1;
      #1 chk("R9 keep high", int'(keep), 1);
      watch(6);
      chk("R1/R2/R3 perr position", pfirst, int'(TBL[v].pd));
      chk("R1 R2 perr one pulse", pcnt, (TBL[v].pd != 0) ? 1 : 0);
      chk("R4 serr position", sfirst, TBL[v].xs ? int'(TBL[v].pd) : 0);
      chk("R3 R5 R7 status", int'(sts), int'(TBL[v].sts));
      chk("R5 R6 R7 R8 istat", int'(ist), int'(TBL[v].ist));
      chk("R11 irq", int'(irq), (TBL[v].ist != 0) ? 1 : 0);
      chk("R9 keep low", int'(keep), 0);
    end

    pcix = 1'b1; per_en = 1'b1; serr_en = 1'b0; udr_en = 1'b0; sdie = 1'b0; imask = 3'b000;
    clear_all();
    @(negedge clk); par_err = 1'b1;
    @(negedge clk);
    pfirst = 0; pcnt = 0;
    for (int k = 2; k <= 7; k++) begin
      @(negedge clk);
      par_err = 1'b0;
      if (!perr_n) begin if (pfirst == 0) pfirst = k; pcnt++; end
    end
    chk("R12 first pulse", pfirst, 3);
    chk("R12 pulse count", pcnt, 2);

    per_en = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    chk("R10 cleared", int'(sts), 0);
    chk("R11 irq cleared", int'(irq), 0);
    par_err = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0100;
    @(negedge clk); par_err = 1'b0; wr_en = 1'b0;
    chk("R10 set wins", int'(sts[2]), 1);
    repeat (4) @(negedge clk);
    chk("R10 sticky", int'(sts[2]), 1);
    wr_en = 1'b1; wr_data = 4'b0100;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 w1c status", int'(sts[2]), 0);
    chk("R10 istat untouched", int'(ist[3]), 1);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b1000;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 w1c istat", int'(ist), 0);
    chk("R11 irq low", int'(irq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule